// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupt Detection

This block is a single 32-pin general-purpose I/O bank that sits behind a plain 32-bit register bus. Software sets each pin's direction, loads an output latch that drives the pads, and reads pin levels through a two-flop synchronizer. Because the input path is synchronized, the value register shows the level on the pad, not the level being driven. It is also delayed. A separate read-only register returns the output latch itself, so software can read back exactly what it wrote.

Each pin also has an event detector. Three type bits per pin select one of five triggers: rising edge, falling edge, both edges, high level or low level. A detected event sets a sticky status bit. This happens whether or not the pin is enabled. Software clears a status bit by writing a 1 to it. One interrupt line goes to the host. It is active while any pin has both its status bit and its enable bit set.

The bus is a single-cycle write strobe with a combinational read mux. The asynchronous reset is released through a two-flop reset synchronizer.

Top module: `gpio_irq_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register reads zero and `pin_out`, `pin_oe` and `irq` are low. Reset assertion takes effect without a clock edge.
- R2: The direction register at offset 0x04 drives `pin_oe` one bit per pin. A 1 means output and a 0 means input. The register reads back what was written.
- R3: A write to offset 0x00 loads all 32 bits of the output latch, and `pin_out` follows the latch. Offset 0x08 returns the latch contents. Writes to 0x08 have no effect.
- R4: A read of offset 0x00 returns `pin_in` through two flops. This holds whatever the direction setting is. A level sampled at clock edge k is readable after edge k+1 and not before.
- R5: The interrupt registers are enable 0x10, type0 0x14, type1 0x18, type2 0x1C and status 0x20. The trigger bits {type2,type1,type0} decode as follows. With type1=1 the trigger is a level: type0=1 means high and type0=0 means low. With type1=0 the trigger is an edge: type2=1 means both edges; otherwise type0=1 means rising and type0=0 means falling.
- R6: An edge status bit is set on the clock edge after the synchronized value of its pin changes. That is one cycle after the new level becomes readable at 0x00.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves the bit unchanged. Only such writes, or reset, ever clear a status bit.
- R8: A level-type status bit that is cleared while its level is still active reads 0 for one cycle and then sets again. An edge event that arrives in the same cycle as a clear of its bit is kept.
- R9: Status bits set whether or not the pin is enabled. `irq` is high exactly when some pin has both status and enable set, and it changes in the same cycle as those registers.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Output latch to the pads |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |
| irq | output | 1 | Host interrupt, OR of enabled status bits |

## Verification
A wrong bit in the direction register or the output latch shows on `pin_oe` or `pin_out` in the same cycle it appears. A wrong status bit, or a wrong enable bit, shows on `irq` at once when its partner bit is set. Otherwise it shows only when software reads offset 0x20. A wrong trigger decode or previous-sample register stays hidden until the pin toggles; the status bit then sets one cycle early or late, or not at all. For this reason the reference model drives random pin traffic while it compares status and `irq` on every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int SYNC_DEPTH = 2;

  localparam logic [ADDR_W-1:0] OFS_PINVAL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_LATCH   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_EVGRP   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_EVEN    = OFS_EVGRP + 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TSEL0   = OFS_EVGRP + 8'h04;
  localparam logic [ADDR_W-1:0] OFS_TSEL1   = OFS_EVGRP + 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TSEL2   = OFS_EVGRP + 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_EVSTS   = OFS_EVGRP + 8'h10;

  // Per-pin trigger selection as seen by the detector
  typedef struct packed {
    logic both;   // type2
    logic level;  // type1
    logic pol;    // type0: high/rising when set
  } trig_sel_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] shf_q;
  logic [1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) shf_q <= '0;
    else         shf_q <= shf_d;
  end

  assign rst_no = shf_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPIN-1:0]   sync_val,
  input  logic [NPIN-1:0]   sts,
  output logic [DATA_W-1:0] rdata,
  output logic [NPIN-1:0]   dir,
  output logic [NPIN-1:0]   lat,
  output logic [NPIN-1:0]   ien,
  output logic [NPIN-1:0]   tsel0,
  output logic [NPIN-1:0]   tsel1,
  output logic [NPIN-1:0]   tsel2,
  output logic [NPIN-1:0]   sts_clr
);
  localparam int NREG = 6;
  localparam logic [ADDR_W-1:0] WOFS [NREG] =
    '{OFS_DIR, OFS_PINVAL, OFS_EVEN, OFS_TSEL0, OFS_TSEL1, OFS_TSEL2};

  logic [NREG-1:0] we;
  logic [NPIN-1:0] reg_q [NREG];
  logic [NPIN-1:0] wval;

  assign wval = wdata[NPIN-1:0];

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign we[r] = wr && (addr == WOFS[r]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     reg_q[r] <= '0;
        else if (we[r]) reg_q[r] <= wval;
      end
    end
  endgenerate

  assign dir   = reg_q[0];
  assign lat   = reg_q[1];
  assign ien   = reg_q[2];
  assign tsel0 = reg_q[3];
  assign tsel1 = reg_q[4];
  assign tsel2 = reg_q[5];

  // write-one-to-clear strobe for the status array
  always_comb begin
    sts_clr = '0;
    if (wr && (addr == OFS_EVSTS)) sts_clr = wval;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_PINVAL: rdata[NPIN-1:0] = sync_val;
      OFS_DIR:    rdata[NPIN-1:0] = dir;
      OFS_LATCH:  rdata[NPIN-1:0] = lat;
      OFS_EVEN:   rdata[NPIN-1:0] = ien;
      OFS_TSEL0:  rdata[NPIN-1:0] = tsel0;
      OFS_TSEL1:  rdata[NPIN-1:0] = tsel1;
      OFS_TSEL2:  rdata[NPIN-1:0] = tsel2;
      OFS_EVSTS:  rdata[NPIN-1:0] = sts;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] cur,
  input  logic [NPIN-1:0] tsel0,
  input  logic [NPIN-1:0] tsel1,
  input  logic [NPIN-1:0] tsel2,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] sts
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] sts_q;
  logic [NPIN-1:0] sts_d;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      trig_sel_t sel;
      logic      rise;
      logic      fall;
      logic      edge_hit;
      logic      lvl_hit;

      assign sel      = '{both: tsel2[p], level: tsel1[p], pol: tsel0[p]};
      assign rise     = cur[p] & ~prev_q[p];
      assign fall     = ~cur[p] & prev_q[p];
      assign edge_hit = sel.both ? (rise | fall) : (sel.pol ? rise : fall);
      assign lvl_hit  = sel.pol ? cur[p] : ~cur[p];
      assign hit[p]   = sel.level ? lvl_hit : edge_hit;
      assign lvl[p]   = sel.level;

      // a clear drops level hits for one cycle but keeps a coincident edge
      always_comb begin
        if (clr[p]) sts_d[p] = hit[p] & ~lvl[p];
        else        sts_d[p] = sts_q[p] | hit[p];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts = sts_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  logic            rst_n_int;
  logic [NPIN-1:0] pin_sync;
  logic [NPIN-1:0] sts_q;
  logic [NPIN-1:0] ien_q;
  logic [NPIN-1:0] ts0;
  logic [NPIN-1:0] ts1;
  logic [NPIN-1:0] ts2;
  logic [NPIN-1:0] clr;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_int)
  );

  gpio_in_sync #(.W(NPIN), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .d_async (pin_in),
    .q_sync  (pin_sync)
  );

  gpio_regs #(.NPIN(NPIN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .sync_val (pin_sync),
    .sts      (sts_q),
    .rdata    (bus_rdata),
    .dir      (pin_oe),
    .lat      (pin_out),
    .ien      (ien_q),
    .tsel0    (ts0),
    .tsel1    (ts1),
    .tsel2    (ts2),
    .sts_clr  (clr)
  );

  gpio_trig_detect #(.NPIN(NPIN)) u_det (
    .clk   (clk),
    .rst_n (rst_n_int),
    .cur   (pin_sync),
    .tsel0 (ts0),
    .tsel1 (ts1),
    .tsel2 (ts2),
    .clr   (clr),
    .sts   (sts_q)
  );

  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   pin_in,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq,
  input logic [NPIN-1:0]   sts,
  input logic [NPIN-1:0]   sync_val
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_DIR) |=> $stable(pin_oe));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_PINVAL) |=> $stable(pin_out));

  p_sync_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_val == $past(pin_in, 2)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_EVSTS) |=> ((sts & $past(sts)) == $past(sts)));

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(bus_wr && bus_addr == OFS_EVEN) || (sts != $past(sts))));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .irq      (irq),
  .sts      (sts_q),
  .sync_val (pin_sync)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam logic [7:0] A_VAL = 8'h00, A_DIR = 8'h04, A_LAT = 8'h08, A_EN = 8'h10,
                         A_T0 = 8'h14, A_T1 = 8'h18, A_T2 = 8'h1C, A_ST = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // ---------------- reference model ----------------
  bit          m_run = 0;
  logic [31:0] m_dir, m_lat, m_en, m_t0, m_t1, m_t2, m_st;
  logic [31:0] hq[$];
  logic [31:0] m_cur, m_old, m_ns;
  bit          h, c, p, clr;

  function automatic logic [31:0] mdl_rd(logic [7:0] a);
    case (a)
      A_VAL:   return hq[$-1];
      A_DIR:   return m_dir;
      A_LAT:   return m_lat;
      A_EN:    return m_en;
      A_T0:    return m_t0;
      A_T1:    return m_t1;
      A_T2:    return m_t2;
      A_ST:    return m_st;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!m_run) begin
      {m_dir, m_lat, m_en, m_t0, m_t1, m_t2, m_st} = '0;
      hq = '{32'h0, 32'h0, 32'h0};
    end else begin
      m_cur = hq[$-1];
      m_old = hq[$-2];
      for (int i = 0; i < 32; i++) begin
        c = m_cur[i]; p = m_old[i];
        if (m_t1[i])      h = m_t0[i] ? c : !c;
        else if (m_t2[i]) h = (c != p);
        else if (m_t0[i]) h = c && !p;
        else              h = !c && p;
        clr = bus_wr && bus_addr == A_ST && bus_wdata[i];
        m_ns[i] = clr ? (h && !m_t1[i]) : (m_st[i] || h);
      end
      m_st = m_ns;
      if (bus_wr) begin
        case (bus_addr)
          A_DIR: m_dir = bus_wdata;
          A_VAL: m_lat = bus_wdata;
          A_EN:  m_en  = bus_wdata;
          A_T0:  m_t0  = bus_wdata;
          A_T1:  m_t1  = bus_wdata;
          A_T2:  m_t2  = bus_wdata;
          default: ;
        endcase
      end
      hq.push_back(pin_in);
      void'(hq.pop_front());
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_mdl(string req, logic [7:0] a);
    @(negedge clk);
    bus_addr = a; #1;
    chk(req, bus_rdata, mdl_rd(a));
  endtask

  task automatic rd_exp(string req, logic [7:0] a, logic [31:0] e);
    @(negedge clk);
    bus_addr = a; #1;
    chk(req, bus_rdata, e);
  endtask

  // every-clock port comparison against the model
  always @(negedge clk) begin
    if (m_run) begin
      chk("R3 pin_out", pin_out, m_lat);
      chk("R2 pin_oe", pin_oe, m_dir);
      chk("R9 irq", {31'b0, irq}, {31'b0, |(m_st & m_en)});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pin_oe, 32'h0);
    chk("R1 out in reset", pin_out, 32'h0);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_run = 1;
    foreach (hq[i]) ;
    rd_exp("R1 val", A_VAL, 32'h0);
    rd_exp("R1 dir", A_DIR, 32'h0);
    rd_exp("R1 lat", A_LAT, 32'h0);
    rd_exp("R1 en", A_EN, 32'h0);
    rd_exp("R1 t1", A_T1, 32'h0);
    rd_exp("R1 sts", A_ST, 32'h0);

    // R2 direction, R3 latch
    wr(A_DIR, 32'h0000_FFFF);
    rd_exp("R2 dir readback", A_DIR, 32'h0000_FFFF);
    wr(A_VAL, 32'hA5A5_1234);
    rd_exp("R3 latch readback", A_LAT, 32'hA5A5_1234);
    wr(A_LAT, 32'hFFFF_FFFF);
    rd_exp("R3 latch write ignored", A_LAT, 32'hA5A5_1234);

    // R4 synchronizer delay, pins include outputs
    @(negedge clk); pin_in = 32'h0F0F_00F0;
    @(negedge clk); bus_addr = A_VAL; #1;
    chk("R4 not yet visible", bus_rdata, 32'h0);
    @(negedge clk); #1;
    chk("R4 visible after two edges", bus_rdata, 32'h0F0F_00F0);

    // R5 trigger types on pins 0..4
    @(negedge clk); pin_in = 32'h0;
    repeat (4) @(negedge clk);
    wr(A_T0, 32'h0000_000D);
    wr(A_T1, 32'h0000_0018);
    wr(A_T2, 32'h0000_0004);
    wr(A_ST, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    rd_exp("R5 low level only", A_ST, 32'h0000_0010);
    @(negedge clk); pin_in = 32'h0000_001F;
    repeat (4) @(negedge clk);
    rd_exp("R5 rising/both/high", A_ST, 32'h0000_001D);
    wr(A_ST, 32'h0000_001F);
    repeat (2) @(negedge clk);
    rd_exp("R8 high level resets after clear", A_ST, 32'h0000_0008);
    @(negedge clk); pin_in = 32'h0;
    repeat (4) @(negedge clk);
    rd_exp("R5 falling/both/low", A_ST, 32'h0000_001E);

    // R7 write-one-to-clear
    wr(A_ST, 32'h0);
    rd_exp("R7 zero write keeps", A_ST, 32'h0000_001E);
    wr(A_ST, 32'h0000_0002);
    rd_exp("R7 one clears", A_ST, 32'h0000_001C);

    // R8 level bit drops for one cycle only
    wr(A_ST, 32'h0000_0010);
    bus_addr = A_ST; #1;
    chk("R8 cleared cycle", bus_rdata, 32'h0000_000C);
    @(negedge clk); #1;
    chk("R8 set again", bus_rdata, 32'h0000_001C);

    // R9 status regardless of enable, irq gating
    chk("R9 no enable no irq", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h0000_0002);
    #1 chk("R9 enable on clear bit", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h0000_0004);
    #1 chk("R9 enable on set bit", {31'b0, irq}, 32'h1);

    // R6 edge status one cycle after value changes
    wr(A_ST, 32'h0000_0001);
    @(negedge clk); pin_in = 32'h0000_0001;
    @(negedge clk);
    @(negedge clk); bus_addr = A_VAL; #1;
    chk("R6 value bit0", bus_rdata & 32'h1, 32'h1);
    bus_addr = A_ST; #1;
    chk("R6 status not yet", bus_rdata & 32'h1, 32'h0);
    @(negedge clk); #1;
    chk("R6 status set", bus_rdata & 32'h1, 32'h1);

    // R10 unmapped offsets
    rd_exp("R10 unmapped 0x0C", 8'h0C, 32'h0);
    rd_exp("R10 unmapped 0x40", 8'h40, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);
    rd_mdl("R10 en unchanged", A_EN);
    rd_mdl("R10 sts unchanged", A_ST);
    rd_exp("R10 dir unchanged", A_DIR, 32'h0000_FFFF);

    // random traffic against the model (R5 R6 R7 R8 R9)
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ $urandom();
      if ($urandom_range(0, 4) == 0) begin
        bus_wr = 1'b1;
        bus_wdata = $urandom();
        case ($urandom_range(0, 4))
          0: bus_addr = A_EN;
          1: bus_addr = A_T0;
          2: bus_addr = A_T1;
          3: bus_addr = A_T2;
          default: bus_addr = A_ST;
        endcase
      end else begin
        bus_addr = ($urandom_range(0, 1) == 0) ? A_ST : A_VAL;
      end
      #1 chk("R5 R8 random readback", bus_rdata, mdl_rd(bus_addr));
    end
    @(negedge clk); bus_wr = 1'b0;
    rd_mdl("R7 final status", A_ST);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule